// File: doc/BRIEF.md
# NAND Page ECC Accumulator

This block builds a Hamming-style check code while a NAND page streams past it, one byte per accepted beat. The page is cut into 512-byte sub-blocks and each sub-block gets its own 24-bit code. A page is 512, 1024 or 2048 bytes long, so it yields one, two or four codes. Every code is held in a 32-bit value word whose top byte carries a valid flag. The page closes on a beat that carries the last-beat marker. While the final code is being settled, a busy flag in a status byte is set.

A small state machine runs the page. IDLE waits for the first accepted beat. That beat clears all value words and moves the machine to ACCUM, or straight to FINISH if the beat is also marked last. ACCUM folds bytes into the running code. When a sub-block completes without a last marker, its code is stored and the machine stays in ACCUM. If that sub-block was the final one the page size allows, the machine moves to DRAIN instead. A beat marked last in ACCUM moves the machine to FINISH. DRAIN ignores data until a beat marked last arrives, then moves to FINISH. FINISH holds busy for a fixed count of cycles, stores the pending code on its final cycle and returns to IDLE.

Top module: `nand_ecc_accum`

## Requirements
- R1: After reset, all four value words read 0 and the status byte reads 0.
- R2: Each byte sits at a position inside its sub-block: the byte offset (0 to 511) times 8, plus the bit index (0 to 7). This position has 12 bits. For each position bit k, code bit k is the XOR of all data bits whose position has bit k set. Code bit 12+k is the XOR of all data bits whose position has bit k clear. The value word is {1'b0, valid, 6'b0, code[23:0]}, so valid is bit 30.
- R3: When the 512th byte of a sub-block is accepted and that beat is not marked last, the sub-block's code appears in its value word with bit 30 set. The word is readable on the cycle after that beat.
- R4: The page-size input selects how many sub-blocks the page has: 1 gives one, 2 gives two, 3 gives four, and 0 is handled as 1. Beats after the page's last sub-block completes, up to the beat marked last, change nothing.
- R5: After a beat marked last is accepted, status bit 6 (busy) reads 1 for exactly 3 cycles and then reads 0. The pending code and its valid bit appear in the same cycle that busy clears. All other status bits stay 0.
- R6: A beat marked last in the middle of a sub-block closes that sub-block. Its word then holds the code of only the bytes received, including the marked byte.
- R7: The first accepted beat of a new page clears all four value words, valid flags included. The cleared words are visible on the next cycle.
- R8: A beat with the valid input low is ignored. A beat offered while busy is set is also ignored: it neither changes a code nor starts a page.
- R9: The running code restarts at each sub-block boundary. Each word depends only on its own 512 bytes and is stored in order: word 0, then 1, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| page_size_sel | input | 2 | Page size: 1 = 512 B, 2 = 1024 B, 3 = 2048 B (0 handled as 512 B) |
| beat_valid | input | 1 | Data byte present this cycle |
| beat_data | input | 8 | Data byte |
| beat_last | input | 1 | Marks the final beat of the page |
| ecc_values | output | 128 | Four value words; word i occupies bits [32i+31:32i] |
| status_reg | output | 8 | Status byte; bit 6 is busy |

## Verification
A code that completes inside the page can be read on the cycle after its 512th byte is accepted. The clearing effect of a new page's first beat is due on that same next cycle. After a last-marked beat, busy is due on each of the next three cycles. The final code, its valid bit and the clear of busy are all due on the fourth cycle. The bench driver records the absolute cycle number at which each result is due and queues that number with the expected value. The monitor compares each queued item only in the cycle it names, sampling between clock edges, so an output that comes one cycle early or late counts as a miscompare.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCUM  = 2'd1,
        ST_DRAIN  = 2'd2,
        ST_FINISH = 2'd3
    } ecc_state_e;

    // position of the valid flag / busy flag inside a status byte
    localparam int FLAG_POS = 6;
    localparam int STAT_W   = 8;

endpackage

// File: rtl/ecc_parity_update.sv
module ecc_parity_update #(
    parameter int ADDR_W = 9
) (
    input  logic [2*(ADDR_W+3)-1:0] acc_in,
    input  logic [ADDR_W-1:0]       byte_off,
    input  logic [7:0]              data,
    output logic [2*(ADDR_W+3)-1:0] acc_out
);
    localparam int POS_W = ADDR_W + 3;

    logic [POS_W-1:0] odd_p;
    logic [POS_W-1:0] even_p;
    logic             byte_par;

    always_comb begin
        odd_p    = acc_in[POS_W-1:0];
        even_p   = acc_in[2*POS_W-1:POS_W];
        byte_par = ^data;
        // bit-index part of the position
        for (int k = 0; k < 3; k++) begin
            for (int b = 0; b < 8; b++) begin
                if (((b >> k) & 1) == 1) odd_p[k]  = odd_p[k]  ^ data[b];
                else                     even_p[k] = even_p[k] ^ data[b];
            end
        end
        // byte-offset part of the position
        for (int k = 0; k < ADDR_W; k++) begin
            if (byte_off[k]) odd_p[k+3]  = odd_p[k+3]  ^ byte_par;
            else             even_p[k+3] = even_p[k+3] ^ byte_par;
        end
        acc_out = {even_p, odd_p};
    end

endmodule

// File: rtl/ecc_slot_bank.sv
module ecc_slot_bank #(
    parameter int NUM_SLOTS = 4,
    parameter int CODE_W    = 24,
    parameter int WORD_W    = 32,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [CODE_W-1:0]           wr_code,
    output logic [NUM_SLOTS*WORD_W-1:0] values
);
    import nand_ecc_pkg::*;

    localparam int VLD_BIT = WORD_W - STAT_W + FLAG_POS;

    logic [NUM_SLOTS-1:0] vld_q;
    logic [CODE_W-1:0]    code_q [NUM_SLOTS];

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        logic [WORD_W-1:0] word;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                code_q[i] <= '0;
            end else if (clr) begin
                vld_q[i]  <= 1'b0;
                code_q[i] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(i))) begin
                vld_q[i]  <= 1'b1;
                code_q[i] <= wr_code;
            end
        end

        always_comb begin
            word                = '0;
            word[CODE_W-1:0]    = code_q[i];
            word[VLD_BIT]       = vld_q[i];
        end

        assign values[i*WORD_W +: WORD_W] = word;
    end

    // R7
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (vld_q == '0));

    // R3
    store_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> vld_q[$past(wr_idx)]);

endmodule

// File: rtl/ecc_page_ctrl.sv
module ecc_page_ctrl #(
    parameter int SUB_BYTES = 512,
    parameter int NUM_SLOTS = 4,
    parameter int FIN_CYC   = 3,
    parameter int ADDR_W    = $clog2(SUB_BYTES),
    parameter int CODE_W    = 2 * (ADDR_W + 3),
    parameter int IDX_W     = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        page_size_sel,
    input  logic              beat_valid,
    input  logic [7:0]        beat_data,
    input  logic              beat_last,
    output logic              page_clr,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [CODE_W-1:0] wr_code,
    output logic              busy
);
    import nand_ecc_pkg::*;

    localparam int FC_W = (FIN_CYC > 1) ? $clog2(FIN_CYC + 1) : 1;

    ecc_state_e        state_q, state_d;
    logic [ADDR_W-1:0] byte_cnt_q;
    logic [IDX_W-1:0]  sub_idx_q;
    logic [IDX_W-1:0]  last_sub_q;
    logic [CODE_W-1:0] acc_q;
    logic              pend_wr_q;
    logic [FC_W-1:0]   fin_cnt_q;

    logic              take;
    logic              sub_done;
    logic              fin_end;
    logic [CODE_W-1:0] upd_in;
    logic [ADDR_W-1:0] upd_off;
    logic [CODE_W-1:0] upd_out;

    function automatic logic [IDX_W-1:0] last_slot_of(input logic [1:0] sel);
        int n;
        n = (sel == 2'd0) ? 1 : (1 << (int'(sel) - 1));
        if (n > NUM_SLOTS) n = NUM_SLOTS;
        return IDX_W'(n - 1);
    endfunction

    assign take     = beat_valid && ((state_q == ST_IDLE) || (state_q == ST_ACCUM));
    assign sub_done = (byte_cnt_q == ADDR_W'(SUB_BYTES - 1));
    assign fin_end  = (fin_cnt_q == FC_W'(FIN_CYC - 1));
    assign upd_in   = (state_q == ST_IDLE) ? '0 : acc_q;
    assign upd_off  = (state_q == ST_IDLE) ? '0 : byte_cnt_q;

    ecc_parity_update #(.ADDR_W(ADDR_W)) u_upd (
        .acc_in   (upd_in),
        .byte_off (upd_off),
        .data     (beat_data),
        .acc_out  (upd_out)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take) state_d = beat_last ? ST_FINISH : ST_ACCUM;
            end
            ST_ACCUM: begin
                if (take) begin
                    if (beat_last)                              state_d = ST_FINISH;
                    else if (sub_done && sub_idx_q == last_sub_q) state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (beat_valid && beat_last) state_d = ST_FINISH;
            end
            ST_FINISH: begin
                if (fin_end) state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_cnt_q <= '0;
            sub_idx_q  <= '0;
            last_sub_q <= '0;
            acc_q      <= '0;
            pend_wr_q  <= 1'b0;
            fin_cnt_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        last_sub_q <= last_slot_of(page_size_sel);
                        sub_idx_q  <= '0;
                        byte_cnt_q <= ADDR_W'(1);
                        acc_q      <= upd_out;
                        pend_wr_q  <= 1'b1;
                        fin_cnt_q  <= '0;
                    end
                end
                ST_ACCUM: begin
                    if (take) begin
                        if (beat_last) begin
                            acc_q     <= upd_out;
                            pend_wr_q <= 1'b1;
                            fin_cnt_q <= '0;
                        end else if (sub_done) begin
                            acc_q      <= '0;
                            byte_cnt_q <= '0;
                            if (sub_idx_q != last_sub_q) sub_idx_q <= sub_idx_q + 1'b1;
                        end else begin
                            acc_q      <= upd_out;
                            byte_cnt_q <= byte_cnt_q + 1'b1;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (beat_valid && beat_last) begin
                        pend_wr_q <= 1'b0;
                        fin_cnt_q <= '0;
                    end
                end
                ST_FINISH: begin
                    fin_cnt_q <= fin_cnt_q + 1'b1;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        page_clr = (state_q == ST_IDLE) && take;
        busy     = (state_q == ST_FINISH);
        wr_idx   = sub_idx_q;
        wr_code  = busy ? acc_q : upd_out;
        wr_en    = ((state_q == ST_ACCUM) && take && !beat_last && sub_done) ||
                   (busy && fin_end && pend_wr_q);
    end

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !fin_end) |=> busy);

    // R5
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(fin_cnt_q) == FC_W'(FIN_CYC - 1)));

    // R4
    slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx <= last_sub_q));

    // R8
    busy_ignores_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && beat_valid) |=> $stable(acc_q));

endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum #(
    parameter int SUB_BYTES = 512,
    parameter int NUM_SLOTS = 4,
    parameter int FIN_CYC   = 3,
    parameter int WORD_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  page_size_sel,
    input  logic                        beat_valid,
    input  logic [7:0]                  beat_data,
    input  logic                        beat_last,
    output logic [NUM_SLOTS*WORD_W-1:0] ecc_values,
    output logic [7:0]                  status_reg
);
    import nand_ecc_pkg::*;

    localparam int ADDR_W = $clog2(SUB_BYTES);
    localparam int CODE_W = 2 * (ADDR_W + 3);
    localparam int IDX_W  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic              page_clr;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [CODE_W-1:0] wr_code;
    logic              busy;

    ecc_page_ctrl #(
        .SUB_BYTES (SUB_BYTES),
        .NUM_SLOTS (NUM_SLOTS),
        .FIN_CYC   (FIN_CYC),
        .ADDR_W    (ADDR_W),
        .CODE_W    (CODE_W),
        .IDX_W     (IDX_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_size_sel (page_size_sel),
        .beat_valid    (beat_valid),
        .beat_data     (beat_data),
        .beat_last     (beat_last),
        .page_clr      (page_clr),
        .wr_en         (wr_en),
        .wr_idx        (wr_idx),
        .wr_code       (wr_code),
        .busy          (busy)
    );

    ecc_slot_bank #(
        .NUM_SLOTS (NUM_SLOTS),
        .CODE_W    (CODE_W),
        .WORD_W    (WORD_W),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (page_clr),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_code (wr_code),
        .values  (ecc_values)
    );

    always_comb begin
        status_reg           = '0;
        status_reg[FLAG_POS] = busy;
    end

endmodule

// File: tb/nand_ecc_accum_tb.sv
`timescale 1ns/1ps
module nand_ecc_accum_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   page_size_sel = 2'd1;
    logic         beat_valid = 1'b0;
    logic [7:0]   beat_data = 8'h00;
    logic         beat_last = 1'b0;
    logic [127:0] ecc_values;
    logic [7:0]   status_reg;

    nand_ecc_accum u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_size_sel (page_size_sel),
        .beat_valid    (beat_valid),
        .beat_data     (beat_data),
        .beat_last     (beat_last),
        .ecc_values    (ecc_values),
        .status_reg    (status_reg)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          kind;   // 0 value word, 1 status byte
        int          slot;
        logic [31:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int n_checks = 0;
    int n_fails  = 0;
    logic [7:0] pg [0:2047];

    function automatic logic [23:0] ref_code(input int start, input int len);
        logic [11:0] o;
        logic [11:0] e;
        int p;
        o = '0;
        e = '0;
        for (int i = 0; i < len; i++)
            for (int b = 0; b < 8; b++)
                if (pg[start+i][b]) begin
                    p = i * 8 + b;
                    for (int k = 0; k < 12; k++)
                        if (((p >> k) & 1) == 1) o[k] = ~o[k];
                        else                     e[k] = ~e[k];
                end
        return {e, o};
    endfunction

    function automatic logic [31:0] vword(input logic v, input logic [23:0] c);
        return {1'b0, v, 6'b0, c};
    endfunction

    task automatic expect_item(input int due, input int kind, input int slot,
                               input logic [31:0] exp, input string req);
        item_t it;
        it.due = due; it.kind = kind; it.slot = slot; it.exp = exp; it.req = req;
        q.push_back(it);
    endtask

    // one beat, called at a falling edge; returns at the next falling edge
    task automatic beat(input logic [7:0] d, input logic last);
        beat_valid = 1'b1;
        beat_data  = d;
        beat_last  = last;
        @(negedge clk);
        beat_valid = 1'b0;
        beat_last  = 1'b0;
        beat_data  = 8'h5A;
    endtask

    task automatic gap(input int n);
        beat_data  = 8'hFF;   // garbage with valid low
        beat_last  = 1'b1;
        repeat (n) @(negedge clk);
        beat_last  = 1'b0;
    endtask

    // monitor: compare every item in exactly the cycle it names
    initial begin
        forever begin
            @(negedge clk);
            #1;
            for (int i = q.size() - 1; i >= 0; i--) begin
                if (q[i].due <= cyc) begin
                    logic [31:0] act;
                    act = (q[i].kind == 0) ? ecc_values[q[i].slot*32 +: 32] : {24'b0, status_reg};
                    n_checks++;
                    if (q[i].due != cyc || act !== q[i].exp) begin
                        n_fails++;
                        $display("FAIL %s cycle %0d kind %0d slot %0d actual %h expected %h",
                                 q[i].req, cyc, q[i].kind, q[i].slot, act, q[i].exp);
                    end
                    q.delete(i);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired at cycle %0d actual hung expected done", cyc);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int s = 0; s < 4; s++) expect_item(cyc, 0, s, 32'h0, "R1");
        expect_item(cyc, 1, 0, 32'h0, "R1");
        @(negedge clk);

        // ---- Page A: 512 bytes, last on byte 511 (R2, R5, R8)
        page_size_sel = 2'd1;
        for (int i = 0; i < 512; i++) pg[i] = 8'((i * 37 + 11) ^ (i >> 3));
        for (int i = 0; i < 512; i++) beat(pg[i], i == 511);
        begin
            int c;
            c = cyc;
            expect_item(c,     1, 0, 32'h40, "R5");
            expect_item(c + 1, 1, 0, 32'h40, "R5");
            expect_item(c + 2, 1, 0, 32'h40, "R5");
            expect_item(c + 2, 0, 0, 32'h0,  "R5");
            expect_item(c + 3, 1, 0, 32'h00, "R5");
            expect_item(c + 3, 0, 0, vword(1'b1, ref_code(0, 512)), "R2");
            expect_item(c + 6, 0, 0, vword(1'b1, ref_code(0, 512)), "R8");
            expect_item(c + 6, 1, 0, 32'h00, "R8");
            beat(8'hAA, 1'b0);   // offered while busy: ignored (R8)
            gap(8);
        end

        // ---- Page B: 2048 bytes with valid-low gaps (R3, R7, R8, R9)
        page_size_sel = 2'd3;
        for (int i = 0; i < 2048; i++) pg[i] = 8'((i * 113 + 7) ^ (i >> 5) ^ (i >> 9));
        for (int i = 0; i < 2048; i++) begin
            beat(pg[i], i == 2047);
            if (i == 0) expect_item(cyc, 0, 0, 32'h0, "R7");
            if ((i % 512) == 511 && i != 2047) begin
                expect_item(cyc, 0, i / 512, vword(1'b1, ref_code(i - 511, 512)), "R3");
                expect_item(cyc, 0, i / 512 + 1, 32'h0, "R9");
            end
            if ((i % 97) == 50) gap(2);
        end
        begin
            int c;
            c = cyc;
            expect_item(c + 3, 0, 3, vword(1'b1, ref_code(1536, 512)), "R9");
            expect_item(c + 3, 0, 0, vword(1'b1, ref_code(0, 512)), "R9");
            expect_item(c + 3, 0, 1, vword(1'b1, ref_code(512, 512)), "R9");
            gap(6);
        end

        // ---- Page C: size 1024, extra bytes after page full are dropped (R4, R7)
        page_size_sel = 2'd2;
        for (int i = 0; i < 1024; i++) pg[i] = 8'hFF;
        for (int i = 0; i < 1024; i++) begin
            beat(pg[i], 1'b0);
            if (i == 0) expect_item(cyc, 0, 3, 32'h0, "R7");
        end
        for (int i = 0; i < 20; i++) beat(8'(i * 29 + 3), 1'b0);
        beat(8'h3C, 1'b1);
        begin
            int c;
            c = cyc;
            expect_item(c,     1, 0, 32'h40, "R5");
            expect_item(c + 3, 0, 0, vword(1'b1, ref_code(0, 512)), "R4");
            expect_item(c + 3, 0, 1, vword(1'b1, ref_code(512, 512)), "R4");
            expect_item(c + 3, 0, 2, 32'h0, "R4");
            expect_item(c + 3, 0, 3, 32'h0, "R4");
            expect_item(c + 3, 1, 0, 32'h00, "R5");
            gap(6);
        end

        // ---- Page D: size code 0 behaves as 512 (R4)
        page_size_sel = 2'd0;
        for (int i = 0; i < 600; i++) pg[i] = (i == 300) ? 8'h10 : ((i > 512) ? 8'hC3 : 8'h00);
        for (int i = 0; i < 600; i++) beat(pg[i], i == 599);
        begin
            int c;
            c = cyc;
            expect_item(c + 3, 0, 0, vword(1'b1, ref_code(0, 512)), "R4");
            expect_item(c + 3, 0, 1, 32'h0, "R4");
            gap(6);
        end

        // ---- Page E: short page, last in mid sub-block (R6)
        page_size_sel = 2'd3;
        for (int i = 0; i < 100; i++) pg[i] = 8'(i * 5 + 1);
        for (int i = 0; i < 100; i++) beat(pg[i], i == 99);
        begin
            int c;
            c = cyc;
            expect_item(c + 3, 0, 0, vword(1'b1, ref_code(0, 100)), "R6");
            expect_item(c + 3, 0, 1, 32'h0, "R6");
            expect_item(c + 3, 1, 0, 32'h00, "R6");
            gap(6);
        end

        gap(4);
        if (q.size() != 0) begin
            n_fails += q.size();
            $display("FAIL unchecked items actual %0d expected 0", q.size());
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule